// File: doc/BRIEF.md
# Call trap vector dispatcher

This block serves the four call instructions of a processor. When a call is issued, the block produces a strobe and a fixed low-memory trap location, one per call number, starting at 0x48. The software places a status-exchange instruction at each such location. The call's effective address never reaches memory, so a call cannot raise an access trap. The block therefore only records the call's 4-bit R field and does no address checking.

When the exchange instruction at the trap location runs, it presents the new instruction address that it has loaded, together with its bit 9. The block then produces the address of the next instruction. If bit 9 is clear, that address is the loaded address unchanged. If bit 9 is set, the block adds the recorded R field to the loaded address. Each call can then enter one of sixteen consecutive slots, which gives up to 64 routine entries across the four calls. Memory access, the status-word swap and the routines themselves are handled elsewhere.

Top module: `call_trap_dispatch`

## Requirements
- R1: One clock after `call_req` is sampled high with `call_sel` equal to n (1 to 4), `trap_valid` is 1 and `trap_loc` equals 0x48 + n - 1. Call 1 gives 0x48, call 2 gives 0x49, call 3 gives 0x4A and call 4 gives 0x4B.
- R2: `trap_valid` is high for exactly one cycle per accepted call. It is low in every cycle that does not follow an accepted call.
- R3: A call whose `call_sel` lies outside 1 to 4 (the 3-bit values 0, 5, 6 and 7) is ignored. It raises no `trap_valid`, and its R field is not recorded. This is visible in the result of a later indexed exchange.
- R4: One clock after `xchg_valid` is sampled high with `xchg_idx` = 0, `next_valid` is 1 and `next_ia` equals `xchg_ia`. `next_valid` is low in every cycle that does not follow an exchange.
- R5: One clock after `xchg_valid` is sampled high with `xchg_idx` = 1, `next_ia` equals (`xchg_ia` + R). R is the R field of the most recent accepted call, and the sum wraps modulo 2^17.
- R6: When a call and an exchange are sampled in the same cycle, the exchange uses the R field recorded before that cycle. The new call's R field is recorded and is used only by later exchanges.
- R7: While reset is held, and right after it is released, `trap_valid`, `next_valid`, `trap_loc` and `next_ia` are 0. The recorded R field is also 0, so an indexed exchange before any call adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | A call instruction is issued this cycle |
| call_sel | input | 3 | Call number, 1 to 4 valid |
| call_rfield | input | 4 | R field of the call instruction |
| xchg_valid | input | 1 | Exchange instruction at the trap location completes this cycle |
| xchg_idx | input | 1 | Bit 9 of the exchange instruction (index by R field) |
| xchg_ia | input | 17 | New instruction address loaded by the exchange |
| trap_valid | output | 1 | Trap location strobe |
| trap_loc | output | 17 | Trap location for the accepted call |
| next_valid | output | 1 | Next-address strobe |
| next_ia | output | 17 | Address of the next instruction after the exchange |

## Verification
A call and an exchange can fall in the same cycle. In that cycle the R field register is read by the exchange and written by the call. The bench provokes this by issuing every call number with every R field value while an exchange runs in the same cycle, with the index bit alternating. An arithmetic model in the bench expects the sum to use the previously accepted R field. A following indexed exchange, with a base near the top of the address range, must show the new R field only when the call number was valid, with wraparound.

// File: rtl/call_trap_dispatch.sv
module call_trap_dispatch #(
  parameter int IA_W      = 17,
  parameter int RF_W      = 4,
  parameter int SEL_W     = 3,
  parameter int NCALL     = 4,
  parameter int TRAP_BASE = 'h48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_req,
  input  logic [SEL_W-1:0] call_sel,
  input  logic [RF_W-1:0] call_rfield,
  input  logic            xchg_valid,
  input  logic            xchg_idx,
  input  logic [IA_W-1:0] xchg_ia,
  output logic            trap_valid,
  output logic [IA_W-1:0] trap_loc,
  output logic            next_valid,
  output logic [IA_W-1:0] next_ia
);

  localparam logic [IA_W-1:0] BASE = IA_W'(TRAP_BASE);
  localparam logic [IA_W-1:0] LAST = IA_W'(TRAP_BASE + NCALL - 1);

  logic [RF_W-1:0] rf_q;
  logic            call_ok;
  logic [IA_W-1:0] loc_d;
  logic [IA_W-1:0] ia_d;

  assign call_ok = call_req && (call_sel != '0) && (call_sel <= SEL_W'(NCALL));
  assign loc_d   = BASE + IA_W'(call_sel) - IA_W'(1);
  assign ia_d    = xchg_ia + (xchg_idx ? IA_W'(rf_q) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_q       <= '0;
      trap_valid <= 1'b0;
      trap_loc   <= '0;
      next_valid <= 1'b0;
      next_ia    <= '0;
    end else begin
      trap_valid <= call_ok;
      next_valid <= xchg_valid;
      if (call_ok) begin
        rf_q     <= call_rfield;
        trap_loc <= loc_d;
      end
      if (xchg_valid) next_ia <= ia_d;
    end
  end

  assert_trap_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_loc >= BASE && trap_loc <= LAST));

  assert_trap_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    call_ok |=> trap_valid);

  assert_no_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !call_ok) |=> !trap_valid);

  assert_plain_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_valid && !xchg_idx) |=> (next_valid && next_ia == $past(xchg_ia)));

  assert_next_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg_valid |=> !next_valid);

  assert_indexed_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_valid && xchg_idx) |=> (next_ia - $past(xchg_ia)) == IA_W'($past(rf_q)));

  assert_rf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !call_ok |=> $stable(rf_q));

endmodule

// File: tb/test_call_trap_dispatch.sv
`timescale 1ns/1ps
module test_call_trap_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_req = 1'b0;
  logic [2:0]  call_sel = '0;
  logic [3:0]  call_rfield = '0;
  logic        xchg_valid = 1'b0;
  logic        xchg_idx = 1'b0;
  logic [16:0] xchg_ia = '0;
  logic        trap_valid, next_valid;
  logic [16:0] trap_loc, next_ia;

  int tests = 0;
  int fails = 0;
  logic [3:0]  m_rf = '0;
  logic [16:0] m_loc = '0;
  logic [16:0] m_ia = '0;

  call_trap_dispatch i_call_trap_dispatch (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_sel(call_sel),
    .call_rfield(call_rfield), .xchg_valid(xchg_valid), .xchg_idx(xchg_idx),
    .xchg_ia(xchg_ia), .trap_valid(trap_valid), .trap_loc(trap_loc),
    .next_valid(next_valid), .next_ia(next_ia)
  );

  always #2 clk = ~clk;

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit cr, input logic [2:0] cs, input logic [3:0] rf,
                      input bit xv, input bit xi, input logic [16:0] ia, input string tag);
    bit ok_call;
    logic [16:0] e_ia;
    call_req = cr; call_sel = cs; call_rfield = rf;
    xchg_valid = xv; xchg_idx = xi; xchg_ia = ia;
    ok_call = cr && cs >= 3'd1 && cs <= 3'd4;
    e_ia = ia + (xi ? {13'd0, m_rf} : 17'd0);
    @(negedge clk);
    chk(trap_valid == ok_call, {tag, " R2 trap_valid"}, 32'(trap_valid), 32'(ok_call));
    if (ok_call) begin
      m_loc = 17'h48 + 17'(cs) - 17'd1;
      chk(trap_loc == m_loc, {tag, " R1 trap_loc"}, 32'(trap_loc), 32'(m_loc));
      m_rf = rf;
    end
    chk(next_valid == xv, {tag, " R4 next_valid"}, 32'(next_valid), 32'(xv));
    if (xv) begin
      m_ia = e_ia;
      chk(next_ia == e_ia, {tag, xi ? " R5 next_ia" : " R4 next_ia"}, 32'(next_ia), 32'(e_ia));
    end
    call_req = 1'b0; xchg_valid = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk(trap_valid == 1'b0 && next_valid == 1'b0, "R7 strobes in reset", {trap_valid, next_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trap_loc == 17'd0, "R7 trap_loc after reset", 32'(trap_loc), 0);
    chk(next_ia == 17'd0, "R7 next_ia after reset", 32'(next_ia), 0);
    step(1'b0, 3'd0, 4'd0, 1'b1, 1'b1, 17'h00123, "R7 indexed before call");

    for (int n = 0; n < 8; n++) begin
      for (int r = 0; r < 16; r++) begin
        step(1'b1, 3'(n), 4'(r), 1'b1, r[0], 17'h1FFFF - 17'(r * 3), "R6 same cycle");
        step(1'b0, 3'd0, 4'd0, 1'b1, 1'b1, 17'h1FFF0 + 17'(n), "R3 R5 follow-up");
        step(1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 17'd0, "R2 idle");
        chk(trap_loc == m_loc && next_ia == m_ia, "R2 outputs hold", 32'(trap_loc), 32'(m_loc));
      end
    end

    for (int n = 1; n <= 4; n++)
      step(1'b1, 3'(n), 4'(15 - n), 1'b0, 1'b0, 17'd0, "R1 call only");
    step(1'b0, 3'd0, 4'd0, 1'b1, 1'b0, 17'h0ABCD, "R4 plain exchange");
    step(1'b1, 3'd7, 4'd1, 1'b0, 1'b0, 17'd0, "R3 invalid call");
    step(1'b0, 3'd0, 4'd0, 1'b1, 1'b1, 17'h1FFFE, "R5 wrap");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule